// File: doc/BRIEF.md
# Bit-Addressable Internal Data Memory

This block is the internal data memory of an 8-bit microcontroller core: a 256-byte RAM behind a single request port. A separate access-type input picks the kind of access. Byte accesses address the full byte space. Bit accesses take an 8-bit bit address and move a single bit. The low half of the bit space is a window onto sixteen RAM bytes. The high half reaches special function register (SFR) bytes whose address is a multiple of 8. Those bytes sit outside the block and are reached through a read/modify/write port.

Byte accesses also come in two modes. In direct mode the upper half of the byte space (0x80-0xFF) is routed to the SFR port. In indirect mode every address stays in RAM, so the upper 128 bytes of RAM are only reachable indirectly.

A bit write reads the containing byte, replaces one bit and writes the byte back. This takes two cycles, and the block reports busy in the second cycle. The SFR side answers each address with an acknowledge that marks the address as implemented. Unimplemented SFRs read as zero and are never written.

Top module: `idata_bitmem`

## Requirements
- R1: A bit address below 0x80 selects RAM byte 0x20 + bit_addr[6:3] and bit bit_addr[2:0]. A bit read returns that bit in rdata[0] with rdata[7:1] zero. For example, bit address 0x13 is bit 3 of byte 0x22.
- R2: A bit address of 0x80 or above selects the SFR byte {bit_addr[7:3],3'b000} and bit bit_addr[2:0]. This byte is read and written only through the SFR port.
- R3: A bit write changes only the selected bit of the target byte. The other seven bits keep their values.
- R4: A bit write is accepted in one cycle and `busy` is high for exactly the following cycle. In that cycle the merged byte is written. Any request presented while `busy` is high is ignored.
- R5: A direct byte access to 0x80-0xFF goes to the SFR port. A direct byte access to 0x00-0x7F goes to RAM.
- R6: An indirect byte access to any address, including 0x80-0xFF, goes to RAM. `sfr_rd` and `sfr_wr` stay low for it.
- R7: When `sfr_ack` is low the SFR address is unimplemented. A byte or bit read of it returns 0, and `sfr_wr` is never raised for it.
- R8: After reset `busy` and `rvalid` are low and `rdata` is 0x00.
- R9: The result of any read is in `rdata` with `rvalid` high in the cycle after the read is accepted. A write does not raise `rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, taken when busy is low |
| acc_bit | input | 1 | 1 = bit access, 0 = byte access |
| we | input | 1 | 1 = write, 0 = read |
| indirect | input | 1 | Byte accesses: 1 = indirect (always RAM) |
| addr | input | 8 | Byte address or bit address |
| wdata | input | 8 | Write data; bit writes use wdata[0] |
| rdata | output | 8 | Read result, bit reads in bit 0 |
| rvalid | output | 1 | rdata holds a new read result |
| busy | output | 1 | Second cycle of a bit write |
| sfr_addr | output | 8 | SFR byte address |
| sfr_rd | output | 1 | SFR read strobe |
| sfr_wr | output | 1 | SFR write strobe |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data, valid in the same cycle |
| sfr_ack | input | 1 | SFR address is implemented, same cycle |

## Verification
The assertions assume that the SFR side answers `sfr_ack` and `sfr_rdata` combinationally from `sfr_addr` alone. They also assume that an SFR byte does not change between the read and the write-back of a bit write unless the block itself writes it. The bench SFR model meets both: its acknowledge is a fixed function of the address and its storage changes only on `sfr_wr`. Random stimulus always drops `req` during the busy cycle. Requests during busy are driven only in a directed case, where the bench checks that they are dropped.

// File: rtl/idm_pkg.sv
package idm_pkg;
    localparam int DW      = 8;
    localparam int AW      = 8;
    localparam int BIW     = $clog2(DW);
    localparam int WIN_W   = AW - 1 - BIW;
    localparam int DEPTH   = 1 << AW;
    localparam logic [AW-WIN_W-1:0] BIT_WIN_BASE = 4'h2;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_MERGE = 1'b1
    } phase_e;

    typedef struct packed {
        phase_e          phase;
        logic [AW-1:0]   tgt;
        logic [BIW-1:0]  bidx;
        logic            tsfr;
        logic            wbit;
        logic [DW-1:0]   held;
        logic [DW-1:0]   rdata;
        logic            rvalid;
    } idm_state_t;
endpackage

// File: rtl/idm_decode.sv
module idm_decode
    import idm_pkg::*;
(
    input  logic            acc_bit,
    input  logic            indirect,
    input  logic [AW-1:0]   addr,
    output logic [AW-1:0]   tgt,
    output logic [BIW-1:0]  bidx,
    output logic            to_sfr
);
    always_comb begin
        if (acc_bit) begin
            bidx = addr[BIW-1:0];
            if (addr[AW-1]) begin
                tgt    = {addr[AW-1:BIW], {BIW{1'b0}}};
                to_sfr = 1'b1;
            end else begin
                tgt    = {BIT_WIN_BASE, addr[AW-2:BIW]};
                to_sfr = 1'b0;
            end
        end else begin
            bidx   = '0;
            tgt    = addr;
            to_sfr = !indirect && addr[AW-1];
        end
    end
endmodule

// File: rtl/idm_merge.sv
module idm_merge
    import idm_pkg::*;
(
    input  logic [DW-1:0]   old_byte,
    input  logic [BIW-1:0]  bidx,
    input  logic            nbit,
    output logic [DW-1:0]   new_byte
);
    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign new_byte[i] = (bidx == BIW'(i)) ? nbit : old_byte[i];
    end
endmodule

// File: rtl/idm_ram.sv
module idm_ram
    import idm_pkg::*;
(
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [DW-1:0]   wdata,
    input  logic [AW-1:0]   raddr,
    output logic [DW-1:0]   rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/idata_bitmem.sv
module idata_bitmem
    import idm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic            acc_bit,
    input  logic            we,
    input  logic            indirect,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    output logic            rvalid,
    output logic            busy,
    output logic [AW-1:0]   sfr_addr,
    output logic            sfr_rd,
    output logic            sfr_wr,
    output logic [DW-1:0]   sfr_wdata,
    input  logic [DW-1:0]   sfr_rdata,
    input  logic            sfr_ack
);
    idm_state_t q, d;

    logic [AW-1:0]  dec_tgt;
    logic [BIW-1:0] dec_bidx;
    logic           dec_sfr;
    logic [DW-1:0]  ram_rd, merged, src_byte, wr_byte;
    logic [AW-1:0]  wr_addr;
    logic           ram_we, accept, in_merge;

    idm_decode u_dec (
        .acc_bit (acc_bit),
        .indirect(indirect),
        .addr    (addr),
        .tgt     (dec_tgt),
        .bidx    (dec_bidx),
        .to_sfr  (dec_sfr)
    );

    idm_merge u_mrg (
        .old_byte(q.held),
        .bidx    (q.bidx),
        .nbit    (q.wbit),
        .new_byte(merged)
    );

    idm_ram u_ram (
        .clk  (clk),
        .we   (ram_we),
        .waddr(wr_addr),
        .wdata(wr_byte),
        .raddr(dec_tgt),
        .rdata(ram_rd)
    );

    always_comb begin
        d        = q;
        in_merge = (q.phase == PH_MERGE);
        accept   = req && !in_merge;
        src_byte = dec_sfr ? (sfr_ack ? sfr_rdata : '0) : ram_rd;

        sfr_addr  = in_merge ? q.tgt : dec_tgt;
        sfr_rd    = accept && dec_sfr && (!we || acc_bit);
        wr_byte   = in_merge ? merged : wdata;
        wr_addr   = in_merge ? q.tgt : dec_tgt;
        sfr_wdata = wr_byte;
        if (in_merge) begin
            sfr_wr = q.tsfr && sfr_ack;
            ram_we = !q.tsfr;
        end else begin
            sfr_wr = accept && dec_sfr && we && !acc_bit && sfr_ack;
            ram_we = accept && !dec_sfr && we && !acc_bit;
        end

        d.rvalid = accept && !we;
        if (accept && !we) begin
            d.rdata = acc_bit ? {{(DW-1){1'b0}}, src_byte[dec_bidx]} : src_byte;
        end

        if (in_merge) begin
            d.phase = PH_IDLE;
        end else if (accept && acc_bit && we) begin
            d.phase = PH_MERGE;
            d.tgt   = dec_tgt;
            d.bidx  = dec_bidx;
            d.tsfr  = dec_sfr;
            d.wbit  = wdata[0];
            d.held  = src_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata  = q.rdata;
    assign rvalid = q.rvalid;
    assign busy   = (q.phase == PH_MERGE);
endmodule

// File: rtl/idata_bitmem_chk.sv
module idata_bitmem_chk
    import idm_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            req,
    input logic            acc_bit,
    input logic            we,
    input logic            indirect,
    input logic [AW-1:0]   addr,
    input logic            busy,
    input logic            rvalid,
    input logic [AW-1:0]   sfr_addr,
    input logic            sfr_rd,
    input logic            sfr_wr,
    input logic [DW-1:0]   sfr_wdata,
    input logic [DW-1:0]   sfr_rdata,
    input logic            sfr_ack
);
    // R6
    indirect_no_sfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy && !acc_bit && indirect) |-> (!sfr_rd && !sfr_wr));

    // R4
    busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R4
    busy_after_bitwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy && acc_bit && we) |=> busy);

    // R7
    no_unimpl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_wr |-> sfr_ack);

    // R2
    sfr_bit_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sfr_wr) |-> (sfr_addr[BIW-1:0] == '0 && sfr_addr[AW-1]));

    // R3
    one_bit_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sfr_wr) |-> ($countones(sfr_wdata ^ $past(sfr_rdata)) <= 1));

    // R9
    rvalid_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy && !we) |=> rvalid);

    // R9
    no_rvalid_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy && we) |=> !rvalid);
endmodule

bind idata_bitmem idata_bitmem_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .acc_bit  (acc_bit),
    .we       (we),
    .indirect (indirect),
    .addr     (addr),
    .busy     (busy),
    .rvalid   (rvalid),
    .sfr_addr (sfr_addr),
    .sfr_rd   (sfr_rd),
    .sfr_wr   (sfr_wr),
    .sfr_wdata(sfr_wdata),
    .sfr_rdata(sfr_rdata),
    .sfr_ack  (sfr_ack)
);

// File: tb/sim_idata_bitmem.sv
`timescale 1ns/1ps
module sim_idata_bitmem;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0, acc_bit = 1'b0, we = 1'b0, indirect = 1'b0;
    logic [7:0] addr = '0, wdata = '0;
    logic [7:0] rdata, sfr_addr, sfr_wdata, sfr_rdata;
    logic       rvalid, busy, sfr_rd, sfr_wr, sfr_ack;

    int checks = 0, errors = 0;
    int rd_cnt = 0, wr_cnt = 0;
    bit done = 0;

    logic [7:0] ram_m [256];
    logic [7:0] sfr_m [128];
    logic [7:0] sfr_dev [128];

    always #5 clk = ~clk;

    idata_bitmem u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .acc_bit(acc_bit), .we(we),
        .indirect(indirect), .addr(addr), .wdata(wdata), .rdata(rdata),
        .rvalid(rvalid), .busy(busy), .sfr_addr(sfr_addr), .sfr_rd(sfr_rd),
        .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
        .sfr_ack(sfr_ack)
    );

    function automatic logic impl(input logic [7:0] a);
        return a[7] && !(a[6] && a[4:3] == 2'b11);
    endfunction

    assign sfr_ack   = impl(sfr_addr);
    assign sfr_rdata = sfr_ack ? sfr_dev[sfr_addr[6:0]] : 8'hA5;

    always @(posedge clk) begin
        if (sfr_rd) rd_cnt++;
        if (sfr_wr) begin
            wr_cnt++;
            sfr_dev[sfr_addr[6:0]] <= sfr_wdata;
        end
    end

    task automatic check(input string r, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", r, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // expected byte for a read, from R1 R2 R5 R6 R7
    function automatic logic [7:0] exp_read(input logic ab, input logic ind, input logic [7:0] a);
        logic [7:0] b;
        if (ab) begin
            if (a[7]) b = impl({a[7:3], 3'b0}) ? sfr_m[{a[6:3], 3'b0}] : 8'h00;
            else      b = ram_m[{4'h2, a[6:3]}];
            return {7'b0, b[a[2:0]]};
        end
        if (!ind && a[7]) return impl(a) ? sfr_m[a[6:0]] : 8'h00;
        return ram_m[a];
    endfunction

    task automatic model_write(input logic ab, input logic ind, input logic [7:0] a, input logic [7:0] wd);
        if (ab) begin
            if (a[7]) begin
                if (impl({a[7:3], 3'b0})) sfr_m[{a[6:3], 3'b0}][a[2:0]] = wd[0];
            end else begin
                ram_m[{4'h2, a[6:3]}][a[2:0]] = wd[0];
            end
        end else if (!ind && a[7]) begin
            if (impl(a)) sfr_m[a[6:0]] = wd;
        end else begin
            ram_m[a] = wd;
        end
    endtask

    task automatic op(input string r, input logic ab, input logic w, input logic ind,
                      input logic [7:0] a, input logic [7:0] wd);
        logic [7:0] e;
        e = exp_read(ab, ind, a);
        @(negedge clk);
        req = 1; acc_bit = ab; we = w; indirect = ind; addr = a; wdata = wd;
        @(negedge clk);
        req = 0;
        if (!w) begin
            check(r, rdata, e);
            check("R9 rvalid", {7'b0, rvalid}, 8'h01);
        end else begin
            model_write(ab, ind, a, wd);
            if (ab) begin
                check("R4 busy", {7'b0, busy}, 8'h01);
                @(negedge clk);
                check("R4 busy drop", {7'b0, busy}, 8'h00);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
        summary();
    end

    initial begin
        int rc, wc;
        void'($urandom(32'h1D5E));
        for (int i = 0; i < 128; i++) begin
            sfr_dev[i] = 8'($urandom);
            sfr_m[i] = sfr_dev[i];
        end
        repeat (3) @(negedge clk);
        check("R8 busy", {7'b0, busy}, 8'h00);
        check("R8 rvalid", {7'b0, rvalid}, 8'h00);
        check("R8 rdata", rdata, 8'h00);
        rst_n = 1;

        for (int i = 0; i < 256; i++) op("R6 init", 0, 1, 1, 8'(i), 8'($urandom));

        // R1: bit 0x13 is bit 3 of byte 0x22
        op("R6 setup", 0, 1, 1, 8'h22, 8'h08);
        op("R1 bit 0x13", 1, 0, 0, 8'h13, 8'h00);
        op("R1 bit 0x12", 1, 0, 0, 8'h12, 8'h00);
        // R3: set bit 0x7F, rest of 0x2F unchanged
        op("R6 setup", 0, 1, 0, 8'h2F, 8'h00);
        op("R3 bitwr", 1, 1, 0, 8'h7F, 8'h01);
        op("R3 byte 0x2F", 0, 0, 0, 8'h2F, 8'h00);
        op("R3 bitwr", 1, 1, 0, 8'h00, 8'h00);
        op("R3 byte 0x20", 0, 0, 1, 8'h20, 8'h00);
        // R2: bit write into SFR 0x90
        op("R2 bitwr", 1, 1, 0, 8'h95, 8'h01);
        op("R2 sfr byte", 0, 0, 0, 8'h90, 8'h00);
        op("R2 bit rd", 1, 0, 0, 8'h95, 8'h00);
        // R5 and R6: direct vs indirect 0x90
        op("R6 wr", 0, 1, 1, 8'h90, 8'h3C);
        rc = rd_cnt; wc = wr_cnt;
        op("R6 ind rd", 0, 0, 1, 8'h90, 8'h00);
        op("R6 ind wr", 0, 1, 1, 8'h91, 8'hC3);
        check("R6 no sfr rd", 8'(rd_cnt - rc), 8'h00);
        check("R6 no sfr wr", 8'(wr_cnt - wc), 8'h00);
        op("R5 direct sfr", 0, 0, 0, 8'h90, 8'h00);
        op("R5 direct ram", 0, 0, 0, 8'h45, 8'h00);
        // R7: unimplemented 0xD8
        wc = wr_cnt;
        op("R7 wr", 0, 1, 0, 8'hD8, 8'hFF);
        op("R7 bitwr", 1, 1, 0, 8'hDA, 8'h01);
        check("R7 no sfr wr", 8'(wr_cnt - wc), 8'h00);
        op("R7 byte rd", 0, 0, 0, 8'hD8, 8'h00);
        op("R7 bit rd", 1, 0, 0, 8'hDA, 8'h00);
        // R4: request during busy is ignored
        op("R4 setup", 0, 1, 1, 8'h40, 8'h11);
        @(negedge clk);
        req = 1; acc_bit = 1; we = 1; indirect = 0; addr = 8'h05; wdata = 8'h01;
        @(negedge clk);
        model_write(1, 0, 8'h05, 8'h01);
        check("R4 busy", {7'b0, busy}, 8'h01);
        acc_bit = 0; indirect = 1; addr = 8'h40; wdata = 8'h5A;
        @(negedge clk);
        req = 0;
        check("R4 busy drop", {7'b0, busy}, 8'h00);
        op("R4 ignored", 0, 0, 1, 8'h40, 8'h00);
        op("R3 merge", 0, 0, 0, 8'h20, 8'h00);

        for (int i = 0; i < 3000; i++) begin
            logic ab, w, ind;
            logic [7:0] a;
            ab = 1'($urandom); w = 1'($urandom); ind = 1'($urandom);
            a = 8'($urandom);
            if (ind && !ab) begin
                rc = rd_cnt; wc = wr_cnt;
                op("R6 random", ab, w, ind, a, 8'($urandom));
                check("R6 random strobes", 8'((rd_cnt - rc) + (wr_cnt - wc)), 8'h00);
            end else begin
                op(ab ? (a[7] ? "R2 random" : "R1 random") : "R5 random",
                   ab, w, ind, a, 8'($urandom));
            end
        end
        for (int i = 0; i < 16; i++) op("R3 sweep", 0, 0, 0, 8'(8'h20 + i), 8'h00);
        summary();
    end
endmodule